// File: doc/BRIEF.md
# Set-Associative Tag Store with Timestamp LRU

This block keeps the line-address tags of a set-associative cache. The lines form a flat array. The array is split into a power-of-two number of sets, and each set owns a run of consecutive slots. A single request port carries three operations, each answered one cycle after it is accepted. A lookup reports whether a line address is resident and which flat slot holds it. A victim selection picks the slot to be replaced in the addressed set and reports the line address currently stored there. A fill writes a new tag into a given slot.

Recency is kept as true LRU. A global counter advances on every accepted request, and each slot keeps a copy of the counter value from its last refresh. When sharer-aware ranking is enabled, the victim score also weighs a per-slot validity bit and a per-slot sharer count supplied by an external coherence controller. Invalid slots are taken first, then slots with fewer sharers, then older ones.

Between a victim selection and its fill, a second victim selection is held back. Lookups still proceed in that window.

Top module: `lru_tag_store`

## Requirements
- R1: After reset no slot holds a tag, every lookup misses, the global counter is zero, every slot timestamp is zero and every stored tag reads as zero.
- R2: The set index is the line address ANDed with NUM_SETS-1. Set X owns flat slots WAYS*X to WAYS*X+WAYS-1, with WAYS = NUM_LINES/NUM_SETS.
- R3: A lookup (req_op_i = 0) compares the full line address against every filled slot of its set. It returns rsp_hit_o=1 with the flat slot index on a match, and rsp_hit_o=0 with rsp_slot_o=0 otherwise.
- R4: A lookup hit refreshes the slot's recency only when req_upd_i is 1. With req_upd_i at 0, the replacement order is left unchanged.
- R5: The global counter increases by one on every accepted request. A refreshed slot takes the incremented value, so a larger timestamp means more recently used.
- R6: A victim selection (req_op_i = 1) returns the flat index of the lowest-scoring slot of the set, together with that slot's stored line address (zero if the slot was never filled). Ties go to the lowest way.
- R7: In sharer-aware mode the score orders slots by validity first (slot_valid_i = 0 lowest), then by sharer count, then by timestamp. Sharer count for slot i is slot_sharers_i[i*SHARER_W +: SHARER_W]. With sharer awareness off, the score is the timestamp alone.
- R8: A fill (req_op_i = 2) writes req_addr_i into slot req_slot_i, marks the slot as holding a tag and refreshes it as most recently used.
- R9: After an accepted victim selection, req_ready_o is 0 for further victim selections until a fill is accepted. Lookups and fills stay accepted during that time.
- R10: rsp_valid_o is high for exactly one cycle, in the cycle after each accepted request, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_op_i | input | 2 | 0 lookup, 1 victim selection, 2 fill |
| req_addr_i | input | ADDR_W | Line address (block offset already removed) |
| req_slot_i | input | SLOT_W | Flat slot index for a fill |
| req_upd_i | input | 1 | Lookup hit refreshes recency |
| slot_valid_i | input | NUM_LINES | Per-slot validity from the coherence controller |
| slot_sharers_i | input | NUM_LINES*SHARER_W | Per-slot sharer counts, packed by slot |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Lookup matched |
| rsp_slot_o | output | SLOT_W | Matched slot or chosen victim slot |
| rsp_victim_addr_o | output | ADDR_W | Line address stored in the victim slot |

## Verification
The bench builds the block with 16 lines in 4 sets of 4 ways, 16-bit line addresses, 3-bit sharer counts and sharer-aware ranking enabled. This size lets one set be filled and then recycled several times, so that the victim order exposes refreshed versus unrefreshed lookups, invalid slots, sharer counts and timestamp ties. Neighbouring sets are left empty or lightly filled, which exercises the flat index layout and full-address compare across sets. The bench drives the per-slot validity and sharer inputs itself, acting as the coherence controller.

// File: rtl/lts_pkg.sv
package lts_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP  = 2'd0,
    OP_PREINS  = 2'd1,
    OP_POSTINS = 2'd2,
    OP_RSVD    = 2'd3
  } lts_op_e;
endpackage

// File: rtl/lts_set_match.sv
module lts_set_match #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 16,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0][ADDR_W-1:0] tags_i,
  input  logic [WAYS-1:0]             filled_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic [WAYS-1:0]             match_o,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_o[w] = filled_i[w] && (tags_i[w] == addr_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match_o[w]) way_o = WAY_W'(w);
  end
  assign hit_o = |match_o;
endmodule

// File: rtl/lts_victim_rank.sv
module lts_victim_rank #(
  parameter int WAYS         = 4,
  parameter int TS_W         = 32,
  parameter int SHARER_W     = 3,
  parameter bit SHARER_AWARE = 1'b1,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SCORE_W = SHARER_AWARE ? (1 + SHARER_W + TS_W) : TS_W
) (
  input  logic [WAYS-1:0][TS_W-1:0]     ts_i,
  input  logic [WAYS-1:0]               valid_i,
  input  logic [WAYS-1:0][SHARER_W-1:0] sharers_i,
  output logic [WAY_W-1:0]              way_o
);
  logic [WAYS-1:0][SCORE_W-1:0] score;

  for (genvar w = 0; w < WAYS; w++) begin : g_score
    if (SHARER_AWARE) begin : g_aware
      // validity dominates, then sharer count, then age
      assign score[w] = {valid_i[w], sharers_i[w], ts_i[w]};
    end else begin : g_plain
      logic unused_in;
      assign unused_in = valid_i[w] ^ (^sharers_i[w]);
      assign score[w]  = ts_i[w];
    end
  end

  always_comb begin
    logic [SCORE_W-1:0] best;
    best  = score[0];
    way_o = '0;
    for (int w = 1; w < WAYS; w++)
      if (score[w] < best) begin  // strict: ties keep the lower way
        best  = score[w];
        way_o = WAY_W'(w);
      end
  end
endmodule

// File: rtl/lru_tag_store.sv
module lru_tag_store
  import lts_pkg::*;
#(
  parameter int NUM_LINES    = 16,
  parameter int NUM_SETS     = 4,
  parameter int ADDR_W       = 16,
  parameter int TS_W         = 32,
  parameter int SHARER_W     = 3,
  parameter bit SHARER_AWARE = 1'b1,
  localparam int WAYS   = NUM_LINES / NUM_SETS,
  localparam int SLOT_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [1:0]                    req_op_i,
  input  logic [ADDR_W-1:0]             req_addr_i,
  input  logic [SLOT_W-1:0]             req_slot_i,
  input  logic                          req_upd_i,
  input  logic [NUM_LINES-1:0]          slot_valid_i,
  input  logic [NUM_LINES*SHARER_W-1:0] slot_sharers_i,
  output logic                          rsp_valid_o,
  output logic                          rsp_hit_o,
  output logic [SLOT_W-1:0]             rsp_slot_o,
  output logic [ADDR_W-1:0]             rsp_victim_addr_o
);
  localparam logic [ADDR_W-1:0] SET_MASK = ADDR_W'(NUM_SETS - 1);

  logic [ADDR_W-1:0] tag_q    [NUM_LINES];
  logic [TS_W-1:0]   ts_q     [NUM_LINES];
  logic [NUM_LINES-1:0] filled_q;
  logic [TS_W-1:0]   gts_q, gts_nxt;
  logic              pend_q;

  logic              acc;
  lts_op_e           op;
  logic [SET_W-1:0]  set_idx;
  logic [SLOT_W-1:0] base;

  logic [WAYS-1:0][ADDR_W-1:0]   set_tags;
  logic [WAYS-1:0][TS_W-1:0]     set_ts;
  logic [WAYS-1:0]               set_filled, set_valid;
  logic [WAYS-1:0][SHARER_W-1:0] set_sh;
  logic [WAYS-1:0]               match;
  logic                          hit;
  logic [WAY_W-1:0]              hit_way, vic_way;
  logic [SLOT_W-1:0]             hit_slot, vic_slot;

  logic              rsp_valid_q, rsp_hit_q;
  logic [SLOT_W-1:0] rsp_slot_q;
  logic [ADDR_W-1:0] rsp_vaddr_q;

  assign op          = lts_op_e'(req_op_i);
  assign req_ready_o = !(pend_q && op == OP_PREINS);
  assign acc         = req_valid_i && req_ready_o;
  assign gts_nxt     = gts_q + TS_W'(1);
  assign set_idx     = SET_W'(req_addr_i & SET_MASK);
  assign base        = SLOT_W'(int'(set_idx) * WAYS);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SLOT_W-1:0] s;
    assign s             = base + SLOT_W'(w);
    assign set_tags[w]   = tag_q[s];
    assign set_ts[w]     = ts_q[s];
    assign set_filled[w] = filled_q[s];
    assign set_valid[w]  = slot_valid_i[s];
    assign set_sh[w]     = slot_sharers_i[int'(s)*SHARER_W +: SHARER_W];
  end

  lts_set_match #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_match (
    .tags_i   (set_tags),
    .filled_i (set_filled),
    .addr_i   (req_addr_i),
    .match_o  (match),
    .hit_o    (hit),
    .way_o    (hit_way)
  );

  lts_victim_rank #(
    .WAYS(WAYS), .TS_W(TS_W), .SHARER_W(SHARER_W), .SHARER_AWARE(SHARER_AWARE)
  ) u_rank (
    .ts_i      (set_ts),
    .valid_i   (set_valid),
    .sharers_i (set_sh),
    .way_o     (vic_way)
  );

  assign hit_slot = base + SLOT_W'(hit_way);
  assign vic_slot = base + SLOT_W'(vic_way);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        tag_q[i] <= '0;
        ts_q[i]  <= '0;
      end
      filled_q    <= '0;
      gts_q       <= '0;
      pend_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_slot_q  <= '0;
      rsp_vaddr_q <= '0;
    end else begin
      rsp_valid_q <= acc;
      if (acc) begin
        gts_q       <= gts_nxt;
        rsp_hit_q   <= 1'b0;
        rsp_slot_q  <= '0;
        rsp_vaddr_q <= '0;
        unique case (op)
          OP_LOOKUP: begin
            rsp_hit_q  <= hit;
            rsp_slot_q <= hit ? hit_slot : '0;
            if (hit && req_upd_i) ts_q[hit_slot] <= gts_nxt;
          end
          OP_PREINS: begin
            rsp_slot_q  <= vic_slot;
            rsp_vaddr_q <= tag_q[vic_slot];
            pend_q      <= 1'b1;
          end
          OP_POSTINS: begin
            tag_q[req_slot_i]    <= req_addr_i;
            ts_q[req_slot_i]     <= gts_nxt;
            filled_q[req_slot_i] <= 1'b1;
            pend_q               <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign rsp_valid_o       = rsp_valid_q;
  assign rsp_hit_o         = rsp_hit_q;
  assign rsp_slot_o        = rsp_slot_q;
  assign rsp_victim_addr_o = rsp_vaddr_q;

  a_r10_rsp_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> rsp_valid_o);
  a_r10_no_rsp_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);
  a_r3_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  a_r3_hit_tag_agrees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op == OP_LOOKUP) |=> (!rsp_hit_o || tag_q[rsp_slot_o] == $past(req_addr_i)));
  a_r5_counter_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> gts_q == $past(gts_q) + TS_W'(1));
  a_r5_counter_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> $stable(gts_q));
  a_r6_victim_in_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op == OP_PREINS) |=> (int'(rsp_slot_o) / WAYS) == int'($past(set_idx)));
  a_r9_pending_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !(acc && op == OP_POSTINS)) |=> pend_q);
  a_r9_preins_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && op == OP_PREINS) |=> pend_q);
endmodule

// File: tb/lru_tag_store_tb_top.sv
module lru_tag_store_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 16, NS = 4, AW = 16, SW = 3, SLW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_upd = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [SLW-1:0] req_slot = '0;
  logic [NL-1:0] s_valid = '0;
  logic [NL*SW-1:0] s_sh = '0;
  logic rsp_valid, rsp_hit;
  logic [SLW-1:0] rsp_slot;
  logic [AW-1:0] rsp_vaddr;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic r_valid, r_hit;
  int r_slot, r_vaddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  lru_tag_store #(.NUM_LINES(NL), .NUM_SETS(NS), .ADDR_W(AW), .TS_W(32),
                  .SHARER_W(SW), .SHARER_AWARE(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_slot_i(req_slot), .req_upd_i(req_upd),
    .slot_valid_i(s_valid), .slot_sharers_i(s_sh), .rsp_valid_o(rsp_valid),
    .rsp_hit_o(rsp_hit), .rsp_slot_o(rsp_slot), .rsp_victim_addr_o(rsp_vaddr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge, accepted at posedge, response sampled at next negedge
  task automatic req(input int op, input int addr, input int slot, input bit upd);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = AW'(addr);
    req_slot = SLW'(slot); req_upd = upd;
    @(negedge clk);
    req_valid = 1'b0; req_upd = 1'b0;
    r_valid = rsp_valid; r_hit = rsp_hit;
    r_slot = int'(rsp_slot); r_vaddr = int'(rsp_vaddr);
    chk("R10 rsp_valid after accept", int'(r_valid), 1);
  endtask

  task automatic lookup(input int addr, input bit upd, input bit ehit, input int eslot, input string tag);
    req(0, addr, 0, upd);
    chk({tag, " hit"}, int'(r_hit), int'(ehit));
    chk({tag, " slot"}, r_slot, eslot);
  endtask

  task automatic victim(input int addr, input int eslot, input int evaddr, input string tag);
    req(1, addr, 0, 1'b0);
    chk({tag, " victim slot"}, r_slot, eslot);
    chk({tag, " victim addr"}, r_vaddr, evaddr);
  endtask

  task automatic fill(input int addr, input int slot);
    req(2, addr, slot, 1'b0);
  endtask

  task automatic t_reset;
    chk("R9 ready after reset", int'(req_ready), 1);
    chk("R10 no rsp when idle", int'(rsp_valid), 0);
    lookup('h0000, 1'b0, 1'b0, 0, "R1 reset lookup addr 0");
    lookup('h0005, 1'b0, 1'b0, 0, "R1 reset lookup addr 5");
  endtask

  task automatic t_fill;
    for (int w = 0; w < 4; w++) begin
      victim('h05 + 16*w, 4 + w, 0, "R6 R7 fill invalid-first");
      fill('h05 + 16*w, 4 + w);
      s_valid[4 + w] = 1'b1;
      lookup('h05 + 16*w, 1'b0, 1'b1, 4 + w, "R8 lookup after fill");
    end
  endtask

  task automatic t_lru;
    victim('h45, 4, 'h05, "R5 oldest valid slot");
    // second selection held back while fill is pending
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_addr = AW'('h45);
    #1 chk("R9 preinsert blocked", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 no response for blocked", int'(rsp_valid), 0);
    lookup('h25, 1'b0, 1'b1, 6, "R9 lookup while pending, R4 no refresh");
    lookup('h15, 1'b1, 1'b1, 5, "R4 lookup with refresh");
    lookup('h75, 1'b0, 1'b0, 0, "R3 miss in full set");
    fill('h45, 4);
    chk("R9 ready after fill", int'(req_ready), 1);
    victim('h55, 6, 'h25, "R4 refreshed slot spared");
    fill('h55, 6);
  endtask

  task automatic t_sharer;
    // recency oldest to newest: 7, 5, 4, 6
    s_sh[7*SW +: SW] = 3'd2;
    victim('h99, 5, 'h15, "R7 sharers raise score");
    fill('h15, 5);
    s_valid[6] = 1'b0;
    victim('h99, 6, 'h55, "R7 invalid beats newer");
    fill('h55, 6);
    s_valid[6] = 1'b1;
    s_sh = '0;
    victim('h99, 7, 'h35, "R7 timestamp order");
    fill('h35, 7);
  endtask

  task automatic t_sets;
    victim('h0A, 8, 0, "R2 set 2 base slot, R6 tie lowest way");
    fill('h0A, 8);
    lookup('h0A, 1'b0, 1'b1, 8, "R2 set 2 hit");
    lookup('h0E, 1'b0, 1'b0, 0, "R3 same set other address");
    lookup('h0B, 1'b0, 1'b0, 0, "R2 set 3 empty");
    victim('h07, 12, 0, "R2 set 3 base slot");
    fill('h07, 12);
    lookup('h07, 1'b0, 1'b1, 12, "R2 set 3 hit");
    lookup('h45, 1'b0, 1'b1, 4, "R8 set 1 intact");
    lookup('h15, 1'b0, 1'b1, 5, "R8 set 1 refilled slot");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_lru();
    t_sharer();
    t_sets();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule